// File: doc/BRIEF.md
# Counter-Sequenced Dot-Product Accumulator

This block multiplies two square N×N matrices of unsigned 16-bit values and produces the product matrix one element at a time. Both operand matrices live in two on-block synchronous memories that are filled through a plain load port. After a start pulse, a sequencer walks a row of the left matrix and a column of the right matrix in lockstep. A single multiplier and a single adder form each dot product.

A down-counter in the accumulate stage decides what happens to the running sum in each cycle. The first product of an element loads the accumulator with no feedback. While the counter is nonzero, each new product is added to the stored sum. When the counter reaches zero, the finished sum moves to the result register and feedback stays off. On that same cycle no product enters, so the cycle is an idle gap before the next element loads. One element therefore takes N+1 cycles.

Results leave as a stream with a valid strobe. There is no ready input, so there is no back-pressure: the consumer must take every result in the cycle its strobe is high. The data stays stable between strobes. Control is a level `busy` and a sticky `done`.

Top module: `mm_engine`

## Requirements
- R1: While `busy` is low, `ld_we`=1 writes `ld_a_data` into the left memory at `ld_a_addr` and `ld_b_data` into the right memory at `ld_b_addr` on the rising edge. The left matrix is row-major (element row i, column k at address i*N+k). The right matrix is also row-major (element row k, column j at address k*N+j).
- R2: A `start` pulse that is sampled while `busy` is low sets `busy` and clears `done` at that same edge.
- R3: Each result equals the sum over k of A[i][k]*B[k][j], taken as unsigned values at full precision with no overflow. For N=3 the result is 34 bits wide, so all-0xFFFF operands give 3*0xFFFE0001.
- R4: Exactly N*N result strobes follow each start, in row-major order (i outer, j inner).
- R5: The first strobe is high N+2 cycles after the start edge, and later strobes follow every N+1 cycles. Two strobes are never adjacent.
- R6: The feedback enable and the output enable are never high together. In the cycle after the output enable, both are low.
- R7: `done` rises and `busy` falls in the same cycle as the final strobe. `done` then stays high until the next accepted start.
- R8: While `busy` is high, `ld_we` and `start` are ignored. Memory contents and the running sequence are left unchanged.
- R9: When no strobe is high, `res_data` holds its previous value.
- R10: After reset, `busy`, `done` and `res_valid` are low and `res_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rst_n | input | 1 | asynchronous reset, active low |
| ld_we | input | 1 | write enable for both memories |
| ld_a_addr | input | AW | left memory load address |
| ld_a_data | input | DW | left memory load data |
| ld_b_addr | input | AW | right memory load address |
| ld_b_data | input | DW | right memory load data |
| start | input | 1 | begin a multiplication |
| busy | output | 1 | multiplication in progress |
| done | output | 1 | sticky completion flag |
| res_valid | output | 1 | result strobe |
| res_data | output | ACCW | result element |

## Verification
Two functions can land in the same cycle: the final result strobe and the completion flag, which must rise together as `busy` falls. The bench watches every cycle after each start and judges that `res_valid`, `done` and `busy` change together on exactly the predicted cycle. A second collision is a load write and a start arriving mid-run. One run injects both and then requires unchanged results, both in that run and in a repeat run without reloading.

// File: rtl/mm_pkg.sv
`timescale 1ns/1ps
package mm_pkg;
  function automatic int clog2m(input int v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction

  typedef enum logic [1:0] {
    MODE_HOLD,
    MODE_LOAD,
    MODE_FEED,
    MODE_EMIT
  } acc_mode_t;
endpackage

// File: rtl/mm_bank.sv
`timescale 1ns/1ps
module mm_bank #(
  parameter int DW    = 16,
  parameter int DEPTH = 9,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];
  logic          in_range;

  assign in_range = int'(addr) < DEPTH;

  always_ff @(posedge clk) begin
    if (we) begin
      if (in_range) store[addr] <= wdata;
    end else begin
      rdata <= in_range ? store[addr] : '0;
    end
  end
endmodule

// File: rtl/mm_seq.sv
`timescale 1ns/1ps
module mm_seq
  import mm_pkg::*;
#(
  parameter int N  = 3,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  output logic          issue_vld,
  output logic [AW-1:0] a_addr,
  output logic [AW-1:0] b_addr
);
  localparam int IW = clog2m(N);
  localparam int KW = clog2m(N + 1);

  logic [IW-1:0] row_q, col_q;
  logic [KW-1:0] k_q, k_eff;
  logic          running_q, at_gap;

  assign at_gap    = (k_q == KW'(N));
  assign issue_vld = running_q && !at_gap;
  assign k_eff     = at_gap ? '0 : k_q;
  assign a_addr    = AW'(32'(row_q) * N + 32'(k_eff));
  assign b_addr    = AW'(32'(k_eff) * N + 32'(col_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q     <= '0;
      col_q     <= '0;
      k_q       <= '0;
      running_q <= 1'b0;
    end else if (launch) begin
      row_q     <= '0;
      col_q     <= '0;
      k_q       <= '0;
      running_q <= 1'b1;
    end else if (running_q) begin
      if (at_gap) begin
        k_q <= '0;
        if (col_q == IW'(N - 1)) begin
          col_q <= '0;
          if (row_q == IW'(N - 1)) running_q <= 1'b0;
          else                     row_q     <= row_q + 1'b1;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end else begin
        k_q <= k_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mm_mac.sv
`timescale 1ns/1ps
module mm_mac
  import mm_pkg::*;
#(
  parameter int N    = 3,
  parameter int DW   = 16,
  parameter int ACCW = 34
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic [DW-1:0]   opa,
  input  logic [DW-1:0]   opb,
  output logic            fb_en,
  output logic            out_en,
  output logic            res_valid,
  output logic [ACCW-1:0] res_data
);
  localparam int CW = clog2m(N);

  logic [2*DW-1:0] prod;
  logic [ACCW-1:0] acc_q;
  logic [CW-1:0]   cnt_q;
  logic            act_q;
  acc_mode_t       mode;

  assign prod = opa * opb;

  always_comb begin
    if (act_q && cnt_q == '0) mode = MODE_EMIT;
    else if (act_q)           mode = MODE_FEED;
    else if (in_vld)          mode = MODE_LOAD;
    else                      mode = MODE_HOLD;
  end

  assign fb_en  = (mode == MODE_FEED);
  assign out_en = (mode == MODE_EMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      cnt_q     <= '0;
      act_q     <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= (mode == MODE_EMIT);
      unique case (mode)
        MODE_LOAD: begin
          acc_q <= ACCW'(prod);
          cnt_q <= CW'(N - 1);
          act_q <= 1'b1;
        end
        MODE_FEED: begin
          acc_q <= acc_q + ACCW'(prod);
          cnt_q <= cnt_q - 1'b1;
        end
        MODE_EMIT: begin
          res_data <= acc_q;
          act_q    <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mm_engine.sv
`timescale 1ns/1ps
module mm_engine
  import mm_pkg::*;
#(
  parameter int N  = 3,
  parameter int DW = 16,
  localparam int DEPTH = N * N,
  localparam int AW    = clog2m(DEPTH),
  localparam int ACCW  = 2 * DW + clog2m(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_we,
  input  logic [AW-1:0]   ld_a_addr,
  input  logic [DW-1:0]   ld_a_data,
  input  logic [AW-1:0]   ld_b_addr,
  input  logic [DW-1:0]   ld_b_data,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic            res_valid,
  output logic [ACCW-1:0] res_data
);
  logic          launch, mem_we, issue_vld, p_vld;
  logic          mac_fb_en, mac_out_en, last_out;
  logic [AW-1:0] ecnt_q;
  logic [AW-1:0] ld_addr  [2];
  logic [DW-1:0] ld_data  [2];
  logic [AW-1:0] seq_addr [2];
  logic [DW-1:0] rd_data  [2];

  assign launch   = start && !busy;
  assign mem_we   = ld_we && !busy;
  assign last_out = mac_out_en && (ecnt_q == AW'(DEPTH - 1));

  assign ld_addr[0] = ld_a_addr;
  assign ld_addr[1] = ld_b_addr;
  assign ld_data[0] = ld_a_data;
  assign ld_data[1] = ld_b_data;

  mm_seq #(.N(N), .AW(AW)) i_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .issue_vld(issue_vld),
    .a_addr(seq_addr[0]), .b_addr(seq_addr[1])
  );

  for (genvar g = 0; g < 2; g++) begin : g_bank
    mm_bank #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) i_bank (
      .clk(clk),
      .we(mem_we),
      .addr(busy ? seq_addr[g] : ld_addr[g]),
      .wdata(ld_data[g]),
      .rdata(rd_data[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) p_vld <= 1'b0;
    else        p_vld <= issue_vld;
  end

  mm_mac #(.N(N), .DW(DW), .ACCW(ACCW)) i_mac (
    .clk(clk), .rst_n(rst_n), .in_vld(p_vld),
    .opa(rd_data[0]), .opb(rd_data[1]),
    .fb_en(mac_fb_en), .out_en(mac_out_en),
    .res_valid(res_valid), .res_data(res_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      ecnt_q <= '0;
    end else if (launch) begin
      busy   <= 1'b1;
      done   <= 1'b0;
      ecnt_q <= '0;
    end else if (last_out) begin
      busy   <= 1'b0;
      done   <= 1'b1;
      ecnt_q <= '0;
    end else if (mac_out_en) begin
      ecnt_q <= ecnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mm_engine_chk.sv
`timescale 1ns/1ps
module mm_engine_chk #(
  parameter int ACCW = 34
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            res_valid,
  input logic [ACCW-1:0] res_data,
  input logic            fb_en,
  input logic            out_en
);
  AST_ENABLES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fb_en && out_en)); // R6
  AST_GAP_AFTER_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |=> (!fb_en && !out_en)); // R6
  AST_STROBE_AFTER_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |=> res_valid); // R4
  AST_NO_ADJACENT_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R5
  AST_DONE_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (res_valid && !busy)); // R7
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_data)); // R9
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R2
endmodule

bind mm_engine mm_engine_chk #(.ACCW(ACCW)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .res_valid(res_valid), .res_data(res_data),
  .fb_en(mac_fb_en), .out_en(mac_out_en)
);

// File: tb/test_mm_engine.sv
`timescale 1ns/1ps
module test_mm_engine;
  localparam int N = 3, DW = 16, NN = N * N, AW = 4, ACCW = 34;
  localparam int FIRST = N + 2, PERIOD = N + 1;
  localparam int LAST  = FIRST + (NN - 1) * PERIOD;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_we = 1'b0, start = 1'b0;
  logic [AW-1:0] ld_a_addr = '0, ld_b_addr = '0;
  logic [DW-1:0] ld_a_data = '0, ld_b_data = '0;
  logic busy, done, res_valid;
  logic [ACCW-1:0] res_data;
  logic [DW-1:0] ma [NN];
  logic [DW-1:0] mb [NN];
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  mm_engine #(.N(N), .DW(DW)) i_mm_engine (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we),
    .ld_a_addr(ld_a_addr), .ld_a_data(ld_a_data),
    .ld_b_addr(ld_b_addr), .ld_b_data(ld_b_data),
    .start(start), .busy(busy), .done(done),
    .res_valid(res_valid), .res_data(res_data)
  );

  function automatic logic [ACCW-1:0] ref_elem(input int e);
    logic [ACCW-1:0] s = '0;
    for (int k = 0; k < N; k++)
      s += ACCW'(ma[(e / N) * N + k]) * ACCW'(mb[k * N + (e % N)]);
    return s;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_all();
    for (int i = 0; i < NN; i++) begin
      @(negedge clk);
      ld_we = 1'b1;
      ld_a_addr = AW'(i); ld_a_data = ma[i];
      ld_b_addr = AW'(i); ld_b_data = mb[i];
    end
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic run(input bit inject);
    @(negedge clk);
    start = 1'b1;
    for (int cyc = 0; cyc <= LAST + 3; cyc++) begin
      @(negedge clk);
      if (cyc == 0) begin
        check("R2 busy after start", 64'(busy), 64'd1);
        check("R2 done cleared", 64'(done), 64'd0);
        start = 1'b0;
      end
      if (inject && cyc == 3) begin  // R8: write and start while busy
        ld_we = 1'b1; start = 1'b1;
        ld_a_addr = '0; ld_a_data = ~ma[0];
        ld_b_addr = '0; ld_b_data = ~mb[0];
      end
      if (inject && cyc == 4) begin
        ld_we = 1'b0; start = 1'b0;
      end
      begin
        automatic bit exp_v = (cyc >= FIRST) && ((cyc - FIRST) % PERIOD == 0) && (cyc <= LAST);
        if (exp_v || res_valid) check("R5 strobe timing", 64'(res_valid), 64'(exp_v));
        if (exp_v) check("R3 R4 element value", 64'(res_data), 64'(ref_elem((cyc - FIRST) / PERIOD)));
      end
      if (cyc == LAST - 1) check("R7 done not early", 64'(done), 64'd0);
      if (cyc == LAST) begin
        check("R7 done with last", 64'(done), 64'd1);
        check("R7 busy falls with last", 64'(busy), 64'd0);
      end
    end
    check("R7 done held", 64'(done), 64'd1);
    check("R9 data held after run", 64'(res_data), 64'(ref_elem(NN - 1)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 busy reset", 64'(busy), 64'd0);
    check("R10 done reset", 64'(done), 64'd0);
    check("R10 valid reset", 64'(res_valid), 64'd0);
    check("R10 data reset", 64'(res_data), 64'd0);

    // R1: identity times random gives B back
    for (int i = 0; i < NN; i++) begin
      ma[i] = (i / N == i % N) ? 16'd1 : 16'd0;
      mb[i] = 16'($urandom());
    end
    load_all();
    run(1'b0);

    // R3: largest operands, no overflow
    for (int i = 0; i < NN; i++) begin ma[i] = 16'hFFFF; mb[i] = 16'hFFFF; end
    load_all();
    run(1'b0);

    // R8: writes and start during a run are ignored, then rerun without reload
    for (int i = 0; i < NN; i++) begin
      ma[i] = 16'($urandom()); mb[i] = 16'($urandom());
    end
    load_all();
    run(1'b1);
    run(1'b0);

    // random runs
    for (int t = 0; t < 4; t++) begin
      for (int i = 0; i < NN; i++) begin
        ma[i] = 16'($urandom()); mb[i] = 16'($urandom());
      end
      load_all();
      run(1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule